// File: doc/BRIEF.md
# USB Control Endpoint Standard Request Responder

This block answers the standard requests that a USB host issues on the default control endpoint of a single-configuration device with one interrupt IN endpoint (address 0x83). It accepts the eight bytes of a SETUP packet in one cycle, decodes them, and produces the endpoint 0 response. A response is one of three kinds. It can be a payload streamed from a parameterized descriptor table. It can be a short status word generated from internal state. It can also be a stall. Every response ends with a byte count and a flag that tells the endpoint logic to acknowledge the status stage.

The block keeps the device-level state that the standard requests act on: the configuration value, the remote-wakeup enable and the halt flag of the IN endpoint. It also drives the signals derived from that state, which are the suspend-interrupt enable and a one-cycle request to reset the IN endpoint data toggle. A bus reset returns all of this state to the unconfigured condition. Address capture is handled elsewhere, so Set_Address only needs the status acknowledge.

The SETUP bytes arrive packed little-endian on `setup_i`. bmRequestType sits in bits 7:0, bRequest in 15:8, wValue in 31:16, wIndex in 47:32 and wLength in 63:48.

Top module: `usb_std_req_resp`

## Requirements
- R1: After `rst_ni` or a one-cycle `bus_reset_i`, the configuration value is 0 and remote wakeup, endpoint halt and the suspend-interrupt enable are all 0. An in-progress response is abandoned.
- R2: A request whose bmRequestType bits 6:5 are not 00 stalls. So does a standard request with a bRequest code outside 0, 1, 3, 5, 6, 8, 9, 10 and 11.
- R3: Every response ends with a one-cycle `resp_done_o`. A stall has `resp_stall_o`=1, `ack_status_o`=0 and count 0. Any other response has `ack_status_o`=1 in that same cycle.
- R4: The payload length is the smaller of wLength and the available length. Payload bytes appear in ascending order, one per cycle with `data_valid_o`, starting the cycle after decode. `resp_done_o` follows the last byte, and `byte_count_o` equals the number of bytes sent. With wLength 0 no byte is sent.
- R5: Get_Descriptor (code 6) selects the descriptor by the high byte of wValue. Type 1 gives the device descriptor, with length at its byte 0 (18 by default). Type 2 gives the configuration descriptor, with length at its byte 2 (34). Type 0x21 gives the slice at configuration offset 18, with length at that slice's byte 0 (9). Type 0x22 gives the report descriptor, with length at configuration offset 25 (17). Any other type stalls.
- R6: Type 3 selects a string by the low byte of wValue, with length at its byte 0. The default strings 0 and 2 are 4 and 8 bytes long. An index of 3 or more stalls.
- R7: Get_Status (code 0) behaves by recipient. With bmRequestType 0x80 it returns {bit1 remote wakeup, bit0 1} then 0x00. With 0x81 it returns 0x00 0x00. With 0x82 and wIndex 0x0083 it returns {bit0 halt} then 0x00. Any other form stalls.
- R8: Set_Feature (3) or Clear_Feature (1) with bmRequestType 0x02, wValue 0 and wIndex 0x0083 sets or clears the endpoint halt. A clear also pulses `toggle_clr_o` in the completion cycle.
- R9: Set_Feature or Clear_Feature with bmRequestType 0x00 and wValue 1 sets or clears remote wakeup. Any other feature request stalls.
- R10: Set_Interface (11) is acknowledged only for wIndex 0 with wValue 0, and stalls otherwise. Get_Interface (10) returns one 0x00 byte for wIndex 0, and stalls otherwise.
- R11: Set_Configuration (9) stores the low byte of wValue, and `suspend_irq_en_o` is high while that value is nonzero. Get_Configuration (8) returns the stored value as one byte.
- R12: Set_Address (5) completes with the status acknowledge and no data.
- R13: A SETUP presented while a response is still in progress is ignored. It produces no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | USB bus reset seen, one cycle |
| setup_valid_i | input | 1 | SETUP bytes valid this cycle |
| setup_i | input | 64 | Eight SETUP bytes, byte 0 in bits 7:0 |
| data_valid_o | output | 1 | Payload byte valid |
| data_o | output | 8 | Payload byte |
| resp_done_o | output | 1 | Response committed |
| resp_stall_o | output | 1 | Response is a stall |
| ack_status_o | output | 1 | Acknowledge the status stage |
| byte_count_o | output | 16 | Payload length of the response |
| cfg_value_o | output | 8 | Current configuration value |
| remote_wake_en_o | output | 1 | Remote wakeup enabled by host |
| ep_halt_o | output | 1 | IN endpoint halted |
| toggle_clr_o | output | 1 | Reset IN endpoint data toggle to DATA0 |
| suspend_irq_en_o | output | 1 | Suspend interrupt detection enabled |

## Verification
The SETUP is sampled on the rising edge E0 and decoded during the next cycle. A stall or a response without data shows `resp_done_o` and its state update in the cycle after edge E1. An N-byte payload occupies the N cycles after E1, and the completion cycle comes right after them. The bench never predicts an absolute cycle. Instead, a monitor samples every falling edge, collects payload bytes while `data_valid_o` is high, and compares the collected bytes, the count, the stall and acknowledge flags and the toggle pulse against the queued expectation at the moment `resp_done_o` appears. State outputs are read only after the queue has drained. The ignored-SETUP case is confirmed by the absence of any extra completion and an unchanged configuration value.

// File: rtl/usb_req_pkg.sv
package usb_req_pkg;

  typedef enum logic [1:0] {ACT_STALL, ACT_NODATA, ACT_ROM, ACT_GEN} act_kind_e;
  typedef enum logic [2:0] {UPD_NONE, UPD_CFG, UPD_RWU_SET, UPD_RWU_CLR,
                            UPD_HALT_SET, UPD_HALT_CLR} upd_e;

  localparam logic [7:0] REQ_GET_STATUS = 8'd0;
  localparam logic [7:0] REQ_CLR_FEAT   = 8'd1;
  localparam logic [7:0] REQ_SET_FEAT   = 8'd3;
  localparam logic [7:0] REQ_SET_ADDR   = 8'd5;
  localparam logic [7:0] REQ_GET_DESC   = 8'd6;
  localparam logic [7:0] REQ_GET_CFG    = 8'd8;
  localparam logic [7:0] REQ_SET_CFG    = 8'd9;
  localparam logic [7:0] REQ_GET_IF     = 8'd10;
  localparam logic [7:0] REQ_SET_IF     = 8'd11;

  localparam logic [7:0] DT_DEVICE = 8'h01;
  localparam logic [7:0] DT_CONFIG = 8'h02;
  localparam logic [7:0] DT_STRING = 8'h03;
  localparam logic [7:0] DT_HID    = 8'h21;
  localparam logic [7:0] DT_REPORT = 8'h22;

  // Default descriptor image, byte 0 of each blob written first
  localparam logic [18*8-1:0] DEV_BLOB = {
    8'h12, 8'h01, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 8'h40, 8'h34,
    8'h12, 8'h78, 8'h56, 8'h01, 8'h00, 8'h01, 8'h02, 8'h00, 8'h01};
  localparam logic [34*8-1:0] CFG_BLOB = {
    8'h09, 8'h02, 8'h22, 8'h00, 8'h01, 8'h01, 8'h00, 8'hE0, 8'h32,
    8'h09, 8'h04, 8'h00, 8'h00, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00,
    8'h09, 8'h21, 8'h10, 8'h01, 8'h00, 8'h01, 8'h22, 8'h11, 8'h00,
    8'h07, 8'h05, 8'h83, 8'h03, 8'h03, 8'h00, 8'h0A};
  localparam logic [17*8-1:0] RPT_BLOB = {
    8'h05, 8'h01, 8'h09, 8'h06, 8'hA1, 8'h01, 8'h75, 8'h08, 8'h95,
    8'h03, 8'h15, 8'h00, 8'h25, 8'h65, 8'h81, 8'h00, 8'hC0};
  localparam logic [4*8-1:0] STR0_BLOB = {8'h04, 8'h03, 8'h09, 8'h04};
  localparam logic [8*8-1:0] STR1_BLOB = {
    8'h08, 8'h03, 8'h55, 8'h00, 8'h53, 8'h00, 8'h42, 8'h00};
  localparam logic [8*8-1:0] STR2_BLOB = {
    8'h08, 8'h03, 8'h4B, 8'h00, 8'h45, 8'h00, 8'h59, 8'h00};

  localparam int DEF_DESC_BYTES = 18 + 34 + 17 + 4 + 8 + 8;
  localparam logic [DEF_DESC_BYTES*8-1:0] DEF_DESC_ROM =
    {DEV_BLOB, CFG_BLOB, RPT_BLOB, STR0_BLOB, STR1_BLOB, STR2_BLOB};
  localparam int DEF_DEV_BASE = 0;
  localparam int DEF_CFG_BASE = 18;
  localparam int DEF_RPT_BASE = 52;
  localparam logic [3*8-1:0] DEF_STR_BASES = {8'd81, 8'd73, 8'd69};

endpackage

// File: rtl/usb_desc_rom.sv
module usb_desc_rom #(
  parameter int DESC_BYTES = 89,
  parameter int ADDR_W = 8,
  parameter int N_RD = 2,
  parameter logic [DESC_BYTES*8-1:0] DESC_ROM = '0
) (
  input  logic [N_RD-1:0][ADDR_W-1:0] rd_addr_i,
  output logic [N_RD-1:0][7:0]        rd_data_o
);
  for (genvar p = 0; p < N_RD; p++) begin : g_port
    always_comb begin
      rd_data_o[p] = 8'h00;
      if (int'(rd_addr_i[p]) < DESC_BYTES)
        rd_data_o[p] = DESC_ROM[(DESC_BYTES - 1 - int'(rd_addr_i[p]))*8 +: 8];
    end
  end
endmodule

// File: rtl/usb_req_decode.sv
module usb_req_decode
  import usb_req_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEV_BASE = 0,
  parameter int CFG_BASE = 18,
  parameter int RPT_BASE = 52,
  parameter int STR_NUM = 3,
  parameter logic [STR_NUM*ADDR_W-1:0] STR_BASES = '0,
  parameter int HID_OFS = 18,
  parameter int RPT_LEN_OFS = 25,
  parameter int CFG_LEN_OFS = 2,
  parameter logic [15:0] EP_IN = 16'h0083
) (
  input  logic [7:0]        bmrt_i,
  input  logic [7:0]        breq_i,
  input  logic [15:0]       wvalue_i,
  input  logic [15:0]       windex_i,
  input  logic [7:0]        cfg_i,
  input  logic              halt_i,
  input  logic              rwu_i,
  output act_kind_e         kind_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] len_addr_o,
  output logic [7:0]        fixed_len_o,
  output logic [15:0]       gen_o,
  output upd_e              upd_o
);
  logic is_set;
  assign is_set = (breq_i == REQ_SET_FEAT);

  always_comb begin
    kind_o      = ACT_STALL;
    base_o      = '0;
    len_addr_o  = '0;
    fixed_len_o = 8'd0;
    gen_o       = 16'h0000;
    upd_o       = UPD_NONE;
    if (bmrt_i[6:5] == 2'b00) begin
      unique case (breq_i)
        REQ_GET_STATUS: begin
          fixed_len_o = 8'd2;
          if (bmrt_i == 8'h80) begin
            kind_o = ACT_GEN;
            gen_o  = {8'h00, 6'b0, rwu_i, 1'b1};
          end else if (bmrt_i == 8'h81) begin
            kind_o = ACT_GEN;
          end else if (bmrt_i == 8'h82 && windex_i == EP_IN) begin
            kind_o = ACT_GEN;
            gen_o  = {8'h00, 7'b0, halt_i};
          end
        end
        REQ_CLR_FEAT, REQ_SET_FEAT: begin
          if (bmrt_i == 8'h02 && wvalue_i == 16'd0 && windex_i == EP_IN) begin
            kind_o = ACT_NODATA;
            upd_o  = is_set ? UPD_HALT_SET : UPD_HALT_CLR;
          end else if (bmrt_i == 8'h00 && wvalue_i == 16'd1) begin
            kind_o = ACT_NODATA;
            upd_o  = is_set ? UPD_RWU_SET : UPD_RWU_CLR;
          end
        end
        REQ_SET_ADDR: kind_o = ACT_NODATA;
        REQ_GET_DESC: begin
          unique case (wvalue_i[15:8])
            DT_DEVICE: begin
              kind_o     = ACT_ROM;
              base_o     = ADDR_W'(DEV_BASE);
              len_addr_o = ADDR_W'(DEV_BASE);
            end
            DT_CONFIG: begin
              kind_o     = ACT_ROM;
              base_o     = ADDR_W'(CFG_BASE);
              len_addr_o = ADDR_W'(CFG_BASE + CFG_LEN_OFS);
            end
            DT_STRING: begin
              if (int'(wvalue_i[7:0]) < STR_NUM) begin
                kind_o     = ACT_ROM;
                base_o     = STR_BASES[int'(wvalue_i[7:0])*ADDR_W +: ADDR_W];
                len_addr_o = base_o;
              end
            end
            DT_HID: begin
              kind_o     = ACT_ROM;
              base_o     = ADDR_W'(CFG_BASE + HID_OFS);
              len_addr_o = ADDR_W'(CFG_BASE + HID_OFS);
            end
            DT_REPORT: begin
              kind_o     = ACT_ROM;
              base_o     = ADDR_W'(RPT_BASE);
              len_addr_o = ADDR_W'(CFG_BASE + RPT_LEN_OFS);
            end
            default: kind_o = ACT_STALL;
          endcase
        end
        REQ_GET_CFG: begin
          kind_o      = ACT_GEN;
          fixed_len_o = 8'd1;
          gen_o       = {8'h00, cfg_i};
        end
        REQ_SET_CFG: begin
          kind_o = ACT_NODATA;
          upd_o  = UPD_CFG;
        end
        REQ_GET_IF: begin
          if (windex_i == 16'd0) begin
            kind_o      = ACT_GEN;
            fixed_len_o = 8'd1;
          end
        end
        REQ_SET_IF: begin
          if (windex_i == 16'd0 && wvalue_i == 16'd0) kind_o = ACT_NODATA;
        end
        default: kind_o = ACT_STALL;
      endcase
    end
  end
endmodule

// File: rtl/usb_req_state.sv
module usb_req_state
  import usb_req_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_reset_i,
  input  logic       commit_i,
  input  upd_e       upd_i,
  input  logic [7:0] cfg_val_i,
  output logic [7:0] cfg_o,
  output logic       rwu_o,
  output logic       halt_o,
  output logic       toggle_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o        <= 8'd0;
      rwu_o        <= 1'b0;
      halt_o       <= 1'b0;
      toggle_clr_o <= 1'b0;
    end else if (bus_reset_i) begin
      cfg_o        <= 8'd0;
      rwu_o        <= 1'b0;
      halt_o       <= 1'b0;
      toggle_clr_o <= 1'b0;
    end else begin
      toggle_clr_o <= 1'b0;
      if (commit_i) begin
        unique case (upd_i)
          UPD_CFG:      cfg_o  <= cfg_val_i;
          UPD_RWU_SET:  rwu_o  <= 1'b1;
          UPD_RWU_CLR:  rwu_o  <= 1'b0;
          UPD_HALT_SET: halt_o <= 1'b1;
          UPD_HALT_CLR: begin
            halt_o       <= 1'b0;
            toggle_clr_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_std_req_resp.sv
module usb_std_req_resp
  import usb_req_pkg::*;
#(
  parameter int DESC_BYTES = usb_req_pkg::DEF_DESC_BYTES,
  parameter int ADDR_W = 8,
  parameter logic [DESC_BYTES*8-1:0] DESC_ROM = usb_req_pkg::DEF_DESC_ROM,
  parameter int DEV_BASE = usb_req_pkg::DEF_DEV_BASE,
  parameter int CFG_BASE = usb_req_pkg::DEF_CFG_BASE,
  parameter int RPT_BASE = usb_req_pkg::DEF_RPT_BASE,
  parameter int STR_NUM = 3,
  parameter logic [STR_NUM*ADDR_W-1:0] STR_BASES = usb_req_pkg::DEF_STR_BASES,
  parameter int HID_OFS = 18,
  parameter int RPT_LEN_OFS = 25,
  parameter int CFG_LEN_OFS = 2,
  parameter logic [15:0] EP_IN = 16'h0083
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_reset_i,
  input  logic        setup_valid_i,
  input  logic [63:0] setup_i,
  output logic        data_valid_o,
  output logic [7:0]  data_o,
  output logic        resp_done_o,
  output logic        resp_stall_o,
  output logic        ack_status_o,
  output logic [15:0] byte_count_o,
  output logic [7:0]  cfg_value_o,
  output logic        remote_wake_en_o,
  output logic        ep_halt_o,
  output logic        toggle_clr_o,
  output logic        suspend_irq_en_o
);
  localparam int N_RD = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_DEC, ST_SEND} st_e;

  st_e                 st_q;
  logic [63:0]         setup_q;
  logic [15:0]         idx_q, cnt_q;
  logic [ADDR_W-1:0]   base_q;
  logic [15:0]         gen_q;
  logic                from_rom_q;

  act_kind_e           act_kind;
  logic [ADDR_W-1:0]   act_base, act_len_addr;
  logic [7:0]          act_fixed;
  logic [15:0]         act_gen;
  upd_e                act_upd;

  logic [N_RD-1:0][ADDR_W-1:0] rd_addr;
  logic [N_RD-1:0][7:0]        rd_data;

  logic [15:0] wlen, avail, cnt;
  logic        streams, commit_upd;

  usb_req_decode #(
    .ADDR_W(ADDR_W), .DEV_BASE(DEV_BASE), .CFG_BASE(CFG_BASE),
    .RPT_BASE(RPT_BASE), .STR_NUM(STR_NUM), .STR_BASES(STR_BASES),
    .HID_OFS(HID_OFS), .RPT_LEN_OFS(RPT_LEN_OFS),
    .CFG_LEN_OFS(CFG_LEN_OFS), .EP_IN(EP_IN)
  ) u_dec (
    .bmrt_i     (setup_q[7:0]),
    .breq_i     (setup_q[15:8]),
    .wvalue_i   (setup_q[31:16]),
    .windex_i   (setup_q[47:32]),
    .cfg_i      (cfg_value_o),
    .halt_i     (ep_halt_o),
    .rwu_i      (remote_wake_en_o),
    .kind_o     (act_kind),
    .base_o     (act_base),
    .len_addr_o (act_len_addr),
    .fixed_len_o(act_fixed),
    .gen_o      (act_gen),
    .upd_o      (act_upd)
  );

  assign rd_addr[0] = base_q + ADDR_W'(idx_q);
  assign rd_addr[1] = act_len_addr;

  usb_desc_rom #(
    .DESC_BYTES(DESC_BYTES), .ADDR_W(ADDR_W), .N_RD(N_RD), .DESC_ROM(DESC_ROM)
  ) u_rom (
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  assign wlen = setup_q[63:48];

  always_comb begin
    unique case (act_kind)
      ACT_ROM: avail = {8'h00, rd_data[1]};
      ACT_GEN: avail = {8'h00, act_fixed};
      default: avail = 16'd0;
    endcase
  end

  assign cnt        = (wlen < avail) ? wlen : avail;
  assign streams    = (act_kind == ACT_ROM || act_kind == ACT_GEN) && cnt != 16'd0;
  assign commit_upd = (st_q == ST_DEC) && (act_kind == ACT_NODATA) && !bus_reset_i;

  usb_req_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .commit_i    (commit_upd),
    .upd_i       (act_upd),
    .cfg_val_i   (setup_q[23:16]),
    .cfg_o       (cfg_value_o),
    .rwu_o       (remote_wake_en_o),
    .halt_o      (ep_halt_o),
    .toggle_clr_o(toggle_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      setup_q      <= '0;
      idx_q        <= '0;
      cnt_q        <= '0;
      base_q       <= '0;
      gen_q        <= '0;
      from_rom_q   <= 1'b0;
      resp_done_o  <= 1'b0;
      resp_stall_o <= 1'b0;
      ack_status_o <= 1'b0;
      byte_count_o <= '0;
    end else if (bus_reset_i) begin
      st_q        <= ST_IDLE;
      resp_done_o <= 1'b0;
    end else begin
      resp_done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (setup_valid_i) begin
            setup_q <= setup_i;
            st_q    <= ST_DEC;
          end
        end
        ST_DEC: begin
          base_q     <= act_base;
          gen_q      <= act_gen;
          from_rom_q <= (act_kind == ACT_ROM);
          cnt_q      <= cnt;
          idx_q      <= '0;
          if (streams) begin
            st_q <= ST_SEND;
          end else begin
            st_q         <= ST_IDLE;
            resp_done_o  <= 1'b1;
            resp_stall_o <= (act_kind == ACT_STALL);
            ack_status_o <= (act_kind != ACT_STALL);
            byte_count_o <= (act_kind == ACT_STALL) ? 16'd0 : cnt;
          end
        end
        ST_SEND: begin
          idx_q <= idx_q + 16'd1;
          if (idx_q == cnt_q - 16'd1) begin
            st_q         <= ST_IDLE;
            resp_done_o  <= 1'b1;
            resp_stall_o <= 1'b0;
            ack_status_o <= 1'b1;
            byte_count_o <= cnt_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign data_valid_o     = (st_q == ST_SEND);
  assign data_o           = from_rom_q ? rd_data[0] : (idx_q[0] ? gen_q[15:8] : gen_q[7:0]);
  assign suspend_irq_en_o = (cfg_value_o != 8'd0);

endmodule

// File: rtl/usb_std_req_resp_chk.sv
module usb_std_req_resp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_reset_i,
  input logic        data_valid_o,
  input logic        resp_done_o,
  input logic        resp_stall_o,
  input logic        ack_status_o,
  input logic [15:0] byte_count_o,
  input logic [7:0]  cfg_value_o,
  input logic        remote_wake_en_o,
  input logic        ep_halt_o,
  input logic        toggle_clr_o,
  input logic        suspend_irq_en_o
);
  logic [15:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (bus_reset_i || resp_done_o) seen_q <= '0;
    else if (data_valid_o) seen_q <= seen_q + 16'd1;
  end

  assert_count_matches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o |-> byte_count_o == seen_q);

  assert_done_after_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o |-> !data_valid_o);

  assert_stall_no_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_done_o && resp_stall_o) |-> (!ack_status_o && byte_count_o == 16'd0));

  assert_bus_reset_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (cfg_value_o == 8'd0 && !remote_wake_en_o && !ep_halt_o && !resp_done_o));

  assert_toggle_on_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_clr_o |-> (resp_done_o && ack_status_o && !ep_halt_o));

  assert_halt_by_request_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ep_halt_o) |-> (resp_done_o && ack_status_o));

  assert_rwu_by_request_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(remote_wake_en_o) |-> (resp_done_o && ack_status_o));

  assert_susp_by_request_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_irq_en_o) |-> (resp_done_o && !resp_stall_o));
endmodule

bind usb_std_req_resp usb_std_req_resp_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bus_reset_i     (bus_reset_i),
  .data_valid_o    (data_valid_o),
  .resp_done_o     (resp_done_o),
  .resp_stall_o    (resp_stall_o),
  .ack_status_o    (ack_status_o),
  .byte_count_o    (byte_count_o),
  .cfg_value_o     (cfg_value_o),
  .remote_wake_en_o(remote_wake_en_o),
  .ep_halt_o       (ep_halt_o),
  .toggle_clr_o    (toggle_clr_o),
  .suspend_irq_en_o(suspend_irq_en_o)
);

// File: tb/usb_std_req_resp_tb.sv
module usb_std_req_resp_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        setup_valid_i = 1'b0;
  logic [63:0] setup_i = '0;
  logic        data_valid_o, resp_done_o, resp_stall_o, ack_status_o;
  logic [7:0]  data_o, cfg_value_o;
  logic [15:0] byte_count_o;
  logic        remote_wake_en_o, ep_halt_o, toggle_clr_o, suspend_irq_en_o;

  always #2.5 clk_i = ~clk_i;

  usb_std_req_resp u_dut (.*);

  typedef struct {
    bit         stall;
    int         cnt;
    int         nchk;
    logic [7:0] b0;
    logic [7:0] b1;
    bit         tog;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_bad = 0, rx_n = 0;
  logic [7:0] rx0, rx1;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [7:0] rt, logic [7:0] rq,
                                     logic [15:0] v, logic [15:0] ix, logic [15:0] ln);
    return {ln, ix, v, rq, rt};
  endfunction

  task automatic drive(input logic [63:0] s);
    @(negedge clk_i);
    setup_valid_i = 1'b1;
    setup_i       = s;
    @(negedge clk_i);
    setup_valid_i = 1'b0;
  endtask

  task automatic issue(input logic [63:0] s, input bit st, input int cnt, input int nchk,
                       input logic [7:0] b0, input logic [7:0] b1, input bit tog,
                       input string tag);
    exp_t it;
    it.stall = st; it.cnt = cnt; it.nchk = nchk;
    it.b0 = b0; it.b1 = b1; it.tog = tog; it.tag = tag;
    q.push_back(it);
    drive(s);
    wait (q.size() == 0);
    @(negedge clk_i);
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (data_valid_o) begin
        if (rx_n == 0) rx0 = data_o;
        if (rx_n == 1) rx1 = data_o;
        rx_n++;
      end
      if (resp_done_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R13", "unexpected response", 1, 0);
        end else begin
          e = q.pop_front();
          chk(resp_stall_o == e.stall, e.tag, "stall", int'(resp_stall_o), int'(e.stall));
          chk(ack_status_o == !e.stall, e.tag, "ack", int'(ack_status_o), int'(!e.stall));
          chk(int'(byte_count_o) == e.cnt, e.tag, "count", int'(byte_count_o), e.cnt);
          chk(rx_n == e.cnt, e.tag, "bytes sent", rx_n, e.cnt);
          if (e.nchk > 0) chk(rx0 == e.b0, e.tag, "byte0", int'(rx0), int'(e.b0));
          if (e.nchk > 1) chk(rx1 == e.b1, e.tag, "byte1", int'(rx1), int'(e.b1));
          chk(toggle_clr_o == e.tog, e.tag, "toggle", int'(toggle_clr_o), int'(e.tog));
        end
        rx_n = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      chk(1'b0, "watchdog", "timeout", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(cfg_value_o == 0 && !remote_wake_en_o && !ep_halt_o && !suspend_irq_en_o &&
        !resp_done_o && !data_valid_o, "R1", "reset state", 0, 0);

    // R5 descriptors and truncation R4
    issue(mk(8'h80, 8'd6, 16'h0100, 16'h0, 16'd64), 0, 18, 2, 8'h12, 8'h01, 0, "R5");
    issue(mk(8'h80, 8'd6, 16'h0100, 16'h0, 16'd8),  0, 8, 2, 8'h12, 8'h01, 0, "R4");
    issue(mk(8'h80, 8'd6, 16'h0200, 16'h0, 16'd255), 0, 34, 2, 8'h09, 8'h02, 0, "R5");
    issue(mk(8'h80, 8'd6, 16'h0200, 16'h0, 16'd9),  0, 9, 2, 8'h09, 8'h02, 0, "R4");
    issue(mk(8'h80, 8'd6, 16'h0200, 16'h0, 16'd0),  0, 0, 0, 8'h00, 8'h00, 0, "R4");
    issue(mk(8'h81, 8'd6, 16'h2100, 16'h0, 16'd64), 0, 9, 2, 8'h09, 8'h21, 0, "R5");
    issue(mk(8'h81, 8'd6, 16'h2200, 16'h0, 16'd255), 0, 17, 0, 8'h00, 8'h00, 0, "R5");
    issue(mk(8'h80, 8'd6, 16'h0700, 16'h0, 16'd64), 1, 0, 0, 8'h00, 8'h00, 0, "R5");
    // R6 strings
    issue(mk(8'h80, 8'd6, 16'h0300, 16'h0409, 16'd255), 0, 4, 2, 8'h04, 8'h03, 0, "R6");
    issue(mk(8'h80, 8'd6, 16'h0302, 16'h0409, 16'd64), 0, 8, 2, 8'h08, 8'h03, 0, "R6");
    issue(mk(8'h80, 8'd6, 16'h0305, 16'h0409, 16'd64), 1, 0, 0, 8'h00, 8'h00, 0, "R6");

    // R7 status, R9 remote wakeup
    issue(mk(8'h80, 8'd0, 16'h0, 16'h0, 16'd2), 0, 2, 2, 8'h01, 8'h00, 0, "R7");
    issue(mk(8'h80, 8'd0, 16'h0, 16'h0, 16'd1), 0, 1, 1, 8'h01, 8'h00, 0, "R4");
    issue(mk(8'h00, 8'd3, 16'h1, 16'h0, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R9");
    chk(remote_wake_en_o == 1'b1, "R9", "rwu set", int'(remote_wake_en_o), 1);
    issue(mk(8'h80, 8'd0, 16'h0, 16'h0, 16'd2), 0, 2, 2, 8'h03, 8'h00, 0, "R7");
    issue(mk(8'h00, 8'd3, 16'h2, 16'h0, 16'd0), 1, 0, 0, 8'h00, 8'h00, 0, "R9");
    issue(mk(8'h00, 8'd1, 16'h1, 16'h0, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R9");
    chk(remote_wake_en_o == 1'b0, "R9", "rwu clear", int'(remote_wake_en_o), 0);
    issue(mk(8'h81, 8'd0, 16'h0, 16'h0, 16'd2), 0, 2, 2, 8'h00, 8'h00, 0, "R7");

    // R8 endpoint halt
    issue(mk(8'h02, 8'd3, 16'h0, 16'h0083, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R8");
    chk(ep_halt_o == 1'b1, "R8", "halt set", int'(ep_halt_o), 1);
    issue(mk(8'h82, 8'd0, 16'h0, 16'h0083, 16'd2), 0, 2, 2, 8'h01, 8'h00, 0, "R7");
    issue(mk(8'h82, 8'd0, 16'h0, 16'h0081, 16'd2), 1, 0, 0, 8'h00, 8'h00, 0, "R7");
    issue(mk(8'h02, 8'd3, 16'h0, 16'h0081, 16'd0), 1, 0, 0, 8'h00, 8'h00, 0, "R9");
    issue(mk(8'h02, 8'd1, 16'h0, 16'h0083, 16'd0), 0, 0, 0, 8'h00, 8'h00, 1, "R8");
    chk(ep_halt_o == 1'b0, "R8", "halt clear", int'(ep_halt_o), 0);
    issue(mk(8'h82, 8'd0, 16'h0, 16'h0083, 16'd2), 0, 2, 2, 8'h00, 8'h00, 0, "R7");

    // R10 interface
    issue(mk(8'h01, 8'd11, 16'h0, 16'h0, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R10");
    issue(mk(8'h01, 8'd11, 16'h1, 16'h0, 16'd0), 1, 0, 0, 8'h00, 8'h00, 0, "R10");
    issue(mk(8'h81, 8'd10, 16'h0, 16'h0, 16'd1), 0, 1, 1, 8'h00, 8'h00, 0, "R10");
    issue(mk(8'h81, 8'd10, 16'h0, 16'h1, 16'd1), 1, 0, 0, 8'h00, 8'h00, 0, "R10");

    // R11 configuration
    issue(mk(8'h00, 8'd9, 16'h1, 16'h0, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R11");
    chk(cfg_value_o == 8'd1 && suspend_irq_en_o, "R11", "config stored",
        int'(cfg_value_o), 1);
    issue(mk(8'h80, 8'd8, 16'h0, 16'h0, 16'd1), 0, 1, 1, 8'h01, 8'h00, 0, "R11");

    // R12 address, R2 type / code stalls
    issue(mk(8'h00, 8'd5, 16'h3, 16'h0, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R12");
    issue(mk(8'h00, 8'd12, 16'h0, 16'h0, 16'd0), 1, 0, 0, 8'h00, 8'h00, 0, "R2");
    issue(mk(8'h21, 8'd9, 16'h0, 16'h0, 16'd0), 1, 0, 0, 8'h00, 8'h00, 0, "R2");
    issue(mk(8'hC0, 8'd6, 16'h0100, 16'h0, 16'd8), 1, 0, 0, 8'h00, 8'h00, 0, "R2");
    issue(mk(8'hE0, 8'd0, 16'h0, 16'h0, 16'd2), 1, 0, 0, 8'h00, 8'h00, 0, "R2");

    // R13 SETUP during a response is dropped
    begin
      exp_t it;
      it.stall = 0; it.cnt = 34; it.nchk = 2; it.b0 = 8'h09; it.b1 = 8'h02;
      it.tog = 0; it.tag = "R13";
      q.push_back(it);
      drive(mk(8'h80, 8'd6, 16'h0200, 16'h0, 16'd255));
      repeat (4) @(negedge clk_i);
      drive(mk(8'h00, 8'd9, 16'h5, 16'h0, 16'd0));
      wait (q.size() == 0);
      repeat (8) @(negedge clk_i);
      chk(cfg_value_o == 8'd1, "R13", "config unchanged", int'(cfg_value_o), 1);
    end

    // R1 bus reset
    issue(mk(8'h00, 8'd3, 16'h1, 16'h0, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R9");
    issue(mk(8'h02, 8'd3, 16'h0, 16'h0083, 16'd0), 0, 0, 0, 8'h00, 8'h00, 0, "R8");
    @(negedge clk_i);
    bus_reset_i = 1'b1;
    @(negedge clk_i);
    bus_reset_i = 1'b0;
    chk(cfg_value_o == 0 && !remote_wake_en_o && !ep_halt_o && !suspend_irq_en_o,
        "R1", "bus reset state", int'(cfg_value_o), 0);
    issue(mk(8'h80, 8'd0, 16'h0, 16'h0, 16'd2), 0, 2, 2, 8'h01, 8'h00, 0, "R1");

    repeat (4) @(negedge clk_i);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule